// File: doc/BRIEF.md
# Low-Power Stop and Wake Controller

This block decides which clocks in a small controller-style system may tick. Each peripheral module has its own stop bit. While that bit is set, the module's functional clock enable stays low. The stop bits themselves sit on the free-running clock, so software can still read and write them while a module, or the whole chip, is stopped.

A whole-chip stop begins when a broadcast bus cycle strobe arrives. On that strobe the block latches the interrupt priority mask that comes with it. It then spends one cycle in a settling state while the system clock enable is still high. After that cycle the system clock enable and every module clock enable go low. The chip stays stopped until one of two things happens: an interrupt arrives whose level is above the latched mask (level 7 always counts), or reset is asserted. On an interrupt wake-up the system clock enable returns one edge later, and a one-cycle flag marks the wake event.

The controller itself runs on the ungated clock. The clock enables it produces go to the clock gating cells elsewhere in the chip.

Top module: `lpw_ctrl`

## Requirements
- R1: While reset is low and just after it is released, the outputs are as follows: `sys_clk_en_o` is 1, `mod_stop_o` and `lp_mask_o` are 0, every bit of `mod_clk_en_o` is 1, and `wake_pulse_o` is 0.
- R2: A write (`wr_en_i`=1) to index `wr_idx_i` loads `wr_stop_i` into stop bit `wr_idx_i` at that clock edge. From then on, `mod_clk_en_o[wr_idx_i]` equals the inverse of the new bit, and the other stop bits keep their values.
- R3: A write whose `wr_idx_i` is not below NUM_MODS changes no stop bit.
- R4: Stop-bit writes take effect in every controller state, including while the system clock enable is low.
- R5: A strobe on `bcast_stb_i` while running loads `bcast_mask_i` into `lp_mask_o` at that edge. `sys_clk_en_o` stays 1 for one more cycle and drops to 0 after the following edge.
- R6: While `sys_clk_en_o` is 0, every bit of `mod_clk_en_o` is 0.
- R7: While stopped, an `irq_lvl_i` strictly greater than `lp_mask_o` raises `sys_clk_en_o` at the next edge. A level equal to or below the mask leaves the block stopped.
- R8: Level 7 (all ones) wakes the block even when the latched mask is 7.
- R9: `wake_pulse_o` is 1 for exactly the first cycle after an interrupt wake-up, and 0 at all other times.
- R10: A strobe that arrives while the block is settling or stopped is ignored: the mask does not change and the block stays stopped.
- R11: Asserting `rst_ni` low while stopped restores `sys_clk_en_o` at once, whatever the mask, and clears the stop bits and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Stop-bit write strobe |
| wr_idx_i | input | IDX_W | Module index of the write |
| wr_stop_i | input | 1 | Value written to the selected stop bit |
| bcast_stb_i | input | 1 | Low-power broadcast cycle strobe |
| bcast_mask_i | input | LVL_W | Interrupt mask carried by the broadcast cycle |
| irq_lvl_i | input | LVL_W | Current pending interrupt priority, 0 meaning none |
| sys_clk_en_o | output | 1 | System clock enable |
| mod_clk_en_o | output | NUM_MODS | Per-module functional clock enables |
| mod_stop_o | output | NUM_MODS | Readback of the stop bits |
| lp_mask_o | output | LVL_W | Latched wake-up mask |
| wake_pulse_o | output | 1 | One-cycle wake event flag |

## Verification
The bench checks the exact cycle in which the system enable drops. A design that skips the settling state drops it one edge too early, and one that waits too long leaves it high after the second edge. It drives an interrupt equal to the mask, so a design that compares with greater-or-equal would wake where it must not. It also drives level 7 against a mask of 7, which a plain comparison would miss. Three further cases target common mistakes: a second strobe while stopped, which a careless design would use to overwrite the mask; a write to an index past the last module, which could alias onto a real bit; and a stop-bit write while stopped, which a design with gated registers would lose.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    // Controller power state; RUN must encode as zero (reset value).
    typedef enum logic [1:0] {
        PM_RUN      = 2'd0,
        PM_STOPPING = 2'd1,
        PM_STOPPED  = 2'd2
    } pm_state_e;

    // Width of an index able to address n modules (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lpw_stop_regs.sv
module lpw_stop_regs #(
    parameter int NUM_MODS = 6,
    parameter int IDX_W    = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic                wr_stop_i,
    output logic [NUM_MODS-1:0] stop_o
);

    typedef struct packed {
        logic [NUM_MODS-1:0] stop;
    } regs_t;

    localparam regs_t REGS_RST = '{stop: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_MODS; i++) begin
            if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                regs_d.stop[i] = wr_stop_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign stop_o = regs_q.stop;

endmodule

// File: rtl/lpw_wake_cmp.sv
module lpw_wake_cmp #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] irq_lvl_i,
    input  logic [LVL_W-1:0] mask_i,
    output logic             wake_o
);

    localparam logic [LVL_W-1:0] LVL_NMI = {LVL_W{1'b1}};

    logic above_mask;
    logic is_nmi;

    always_comb begin
        above_mask = (irq_lvl_i > mask_i);
        is_nmi     = (irq_lvl_i == LVL_NMI);
        wake_o     = above_mask || is_nmi;
    end

endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm
    import lpw_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bcast_stb_i,
    input  logic [LVL_W-1:0] bcast_mask_i,
    input  logic             wake_req_i,
    output pm_state_e        state_o,
    output logic [LVL_W-1:0] mask_o,
    output logic             sys_en_o,
    output logic             wake_pulse_o
);

    typedef struct packed {
        pm_state_e        st;
        logic [LVL_W-1:0] mask;
        logic             pulse;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: PM_RUN, mask: '0, pulse: 1'b0};

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.pulse = 1'b0;
        unique case (fsm_q.st)
            PM_RUN: begin
                if (bcast_stb_i) begin
                    fsm_d.mask = bcast_mask_i;
                    fsm_d.st   = PM_STOPPING;
                end
            end
            PM_STOPPING: begin
                // mask is stable now; enable drops after this edge
                fsm_d.st = PM_STOPPED;
            end
            PM_STOPPED: begin
                if (wake_req_i) begin
                    fsm_d.st    = PM_RUN;
                    fsm_d.pulse = 1'b1;
                end
            end
            default: begin
                fsm_d.st = PM_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= FSM_RST;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o      = fsm_q.st;
    assign mask_o       = fsm_q.mask;
    assign sys_en_o     = (fsm_q.st != PM_STOPPED);
    assign wake_pulse_o = fsm_q.pulse;

endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
    import lpw_pkg::*;
#(
    parameter  int NUM_MODS = 6,
    parameter  int LVL_W    = 3,
    localparam int IDX_W    = lpw_pkg::idx_width(NUM_MODS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic                wr_stop_i,
    input  logic                bcast_stb_i,
    input  logic [LVL_W-1:0]    bcast_mask_i,
    input  logic [LVL_W-1:0]    irq_lvl_i,
    output logic                sys_clk_en_o,
    output logic [NUM_MODS-1:0] mod_clk_en_o,
    output logic [NUM_MODS-1:0] mod_stop_o,
    output logic [LVL_W-1:0]    lp_mask_o,
    output logic                wake_pulse_o
);

    logic [NUM_MODS-1:0] stop_bits;
    logic [LVL_W-1:0]    mask_q;
    logic                wake_req;
    logic                sys_en;
    pm_state_e           pm_state;

    lpw_stop_regs #(
        .NUM_MODS (NUM_MODS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_stop_i (wr_stop_i),
        .stop_o    (stop_bits)
    );

    lpw_wake_cmp #(
        .LVL_W (LVL_W)
    ) u_cmp (
        .irq_lvl_i (irq_lvl_i),
        .mask_i    (mask_q),
        .wake_o    (wake_req)
    );

    lpw_fsm #(
        .LVL_W (LVL_W)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bcast_stb_i  (bcast_stb_i),
        .bcast_mask_i (bcast_mask_i),
        .wake_req_i   (wake_req),
        .state_o      (pm_state),
        .mask_o       (mask_q),
        .sys_en_o     (sys_en),
        .wake_pulse_o (wake_pulse_o)
    );

    // Per-module enable: module not stopped and system clock running.
    for (genvar g = 0; g < NUM_MODS; g++) begin : g_mod_en
        assign mod_clk_en_o[g] = sys_en & ~stop_bits[g];
    end

    assign sys_clk_en_o = sys_en;
    assign mod_stop_o   = stop_bits;
    assign lp_mask_o    = mask_q;

endmodule

// File: rtl/lpw_ctrl_chk.sv
module lpw_ctrl_chk
    import lpw_pkg::*;
#(
    parameter int NUM_MODS = 6,
    parameter int LVL_W    = 3,
    parameter int IDX_W    = 3
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                wr_en_i,
    input logic [IDX_W-1:0]    wr_idx_i,
    input logic                wr_stop_i,
    input logic                bcast_stb_i,
    input logic [LVL_W-1:0]    bcast_mask_i,
    input logic [LVL_W-1:0]    irq_lvl_i,
    input logic                sys_clk_en_o,
    input logic [NUM_MODS-1:0] mod_clk_en_o,
    input logic [NUM_MODS-1:0] mod_stop_o,
    input logic [LVL_W-1:0]    lp_mask_o,
    input logic                wake_pulse_o,
    input pm_state_e           st_i
);

    localparam logic [IDX_W:0]   IDX_LIM = (IDX_W+1)'(NUM_MODS);
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

    p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_idx_i == '0) |=> (mod_stop_o[0] == $past(wr_stop_i)));

    p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ({1'b0, wr_idx_i} >= IDX_LIM)) |=> $stable(mod_stop_o));

    p_mask_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == PM_RUN && bcast_stb_i) |=> (lp_mask_o == $past(bcast_mask_i)));

    p_en_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == PM_STOPPING) |=> !sys_clk_en_o);

    p_mod_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sys_clk_en_o |-> (mod_clk_en_o == '0));

    p_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sys_clk_en_o && irq_lvl_i > lp_mask_o) |=> sys_clk_en_o);

    p_nmi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sys_clk_en_o && irq_lvl_i == LVL_TOP) |=> sys_clk_en_o);

    p_pulse_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_pulse_o |=> !wake_pulse_o);

    p_pulse_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wake_pulse_o) |-> ($past(!sys_clk_en_o) && sys_clk_en_o));

    p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i != PM_RUN && bcast_stb_i) |=> $stable(lp_mask_o));

endmodule

bind lpw_ctrl lpw_ctrl_chk #(
    .NUM_MODS (NUM_MODS),
    .LVL_W    (LVL_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_stop_i    (wr_stop_i),
    .bcast_stb_i  (bcast_stb_i),
    .bcast_mask_i (bcast_mask_i),
    .irq_lvl_i    (irq_lvl_i),
    .sys_clk_en_o (sys_clk_en_o),
    .mod_clk_en_o (mod_clk_en_o),
    .mod_stop_o   (mod_stop_o),
    .lp_mask_o    (lp_mask_o),
    .wake_pulse_o (wake_pulse_o),
    .st_i         (pm_state)
);

// File: tb/lpw_ctrl_bench.sv
`timescale 1ns/1ps
module lpw_ctrl_bench;

    localparam int NM = 6;
    localparam int LW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_stop = 1'b0;
    logic          bcast = 1'b0;
    logic [LW-1:0] bmask = '0;
    logic [LW-1:0] irq = '0;
    logic          sys_en;
    logic [NM-1:0] mod_en;
    logic [NM-1:0] mod_stop;
    logic [LW-1:0] lp_mask;
    logic          wpulse;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lpw_ctrl #(.NUM_MODS(NM), .LVL_W(LW)) u_lpw_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_idx_i     (wr_idx),
        .wr_stop_i    (wr_stop),
        .bcast_stb_i  (bcast),
        .bcast_mask_i (bmask),
        .irq_lvl_i    (irq),
        .sys_clk_en_o (sys_en),
        .mod_clk_en_o (mod_en),
        .mod_stop_o   (mod_stop),
        .lp_mask_o    (lp_mask),
        .wake_pulse_o (wpulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock edge, then settle 1 ns past it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_stop(input int idx, input logic v);
        wr_en   = 1'b1;
        wr_idx  = IW'(idx);
        wr_stop = v;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic enter_stop(input logic [LW-1:0] m);
        bcast = 1'b1;
        bmask = m;
        step();
        bcast = 1'b0;
        step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        #3;
        check("R1 sys_en in reset", 32'(sys_en), 1);
        step();
        rst_n = 1'b1;
        step();
        check("R1 sys_en", 32'(sys_en), 1);
        check("R1 stop bits", 32'(mod_stop), 0);
        check("R1 mask", 32'(lp_mask), 0);
        check("R1 mod_en", 32'(mod_en), 32'h3F);
        check("R1 pulse", 32'(wpulse), 0);
    endtask

    task automatic t_stop_bits();
        write_stop(2, 1'b1);
        check("R2 stop readback", 32'(mod_stop), 32'h04);
        check("R2 mod_en", 32'(mod_en), 32'h3B);
        write_stop(5, 1'b1);
        check("R2 second bit", 32'(mod_stop), 32'h24);
        write_stop(2, 1'b0);
        check("R2 clear bit", 32'(mod_stop), 32'h20);
        check("R2 mod_en after clear", 32'(mod_en), 32'h1F);
    endtask

    task automatic t_range();
        write_stop(6, 1'b1);
        check("R3 idx 6 ignored", 32'(mod_stop), 32'h20);
        write_stop(7, 1'b1);
        check("R3 idx 7 ignored", 32'(mod_stop), 32'h20);
        write_stop(5, 1'b0);
    endtask

    task automatic t_enter_and_wake();
        bcast = 1'b1;
        bmask = 3'd3;
        step();
        bcast = 1'b0;
        check("R5 mask captured", 32'(lp_mask), 3);
        check("R5 enable held one cycle", 32'(sys_en), 1);
        step();
        check("R5 enable dropped", 32'(sys_en), 0);
        check("R6 module enables off", 32'(mod_en), 0);
        irq = 3'd3;
        step();
        check("R7 equal level no wake", 32'(sys_en), 0);
        irq = 3'd2;
        step();
        check("R7 lower level no wake", 32'(sys_en), 0);
        check("R9 no pulse while stopped", 32'(wpulse), 0);
        irq = 3'd4;
        step();
        irq = 3'd0;
        check("R7 wake above mask", 32'(sys_en), 1);
        check("R9 pulse high", 32'(wpulse), 1);
        check("R7 mod_en restored", 32'(mod_en), 32'h3F);
        step();
        check("R9 pulse one cycle", 32'(wpulse), 0);
    endtask

    task automatic t_nmi_and_writes();
        enter_stop(3'd7);
        check("R8 stopped with mask 7", 32'(sys_en), 0);
        write_stop(1, 1'b1);
        check("R4 write while stopped", 32'(mod_stop), 32'h02);
        check("R6 still off", 32'(mod_en), 0);
        irq = 3'd6;
        step();
        check("R8 level 6 no wake", 32'(sys_en), 0);
        irq = 3'd7;
        step();
        irq = 3'd0;
        check("R8 level 7 wakes", 32'(sys_en), 1);
        check("R4 enables follow stop bit", 32'(mod_en), 32'h3D);
        step();
        write_stop(1, 1'b0);
    endtask

    task automatic t_ignore_strobe();
        bcast = 1'b1;
        bmask = 3'd2;
        step();
        bmask = 3'd6;
        step();
        check("R10 strobe in settling ignored", 32'(lp_mask), 2);
        step();
        check("R10 still stopped", 32'(sys_en), 0);
        check("R10 strobe while stopped ignored", 32'(lp_mask), 2);
        bcast = 1'b0;
        irq = 3'd3;
        step();
        irq = 3'd0;
        check("R10 wake uses first mask", 32'(sys_en), 1);
        step();
    endtask

    task automatic t_reset_wake();
        write_stop(0, 1'b1);
        enter_stop(3'd7);
        check("R11 stopped", 32'(sys_en), 0);
        rst_n = 1'b0;
        #1;
        check("R11 reset wakes", 32'(sys_en), 1);
        check("R11 mask cleared", 32'(lp_mask), 0);
        check("R11 stop bits cleared", 32'(mod_stop), 0);
        step();
        rst_n = 1'b1;
        step();
        check("R11 running after release", 32'(sys_en), 1);
    endtask

    initial begin
        t_reset_state();
        t_stop_bits();
        t_range();
        t_enter_and_wake();
        t_nmi_and_writes();
        t_ignore_strobe();
        t_reset_wake();
        do_reset();
        check("R1 sys_en after final reset", 32'(sys_en), 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule